// File: doc/BRIEF.md
# Sticky Diagnostic Error Aggregator

This block merges a card's diagnostic signals into a single registered card error flag. Three active-low error lines are decoded according to the operating mode. In normal operation any one line pulled low flags an error. In self-test operation the lines are deliberately driven low, so only the case where all of them are low together counts as the expected error response.

Two active-high driver-fault lines bypass the mode decoding. Either one raises the card error and sets a sticky latch. The latch keeps the error raised after the fault goes away, until an operator clear pulse arrives while no fault is present. After leaving self-test, the operator or the test sequencer issues a clear pulse to return the card to the no-error state.

Every input passes through a two-stage synchronizer before it is used. The output flag is registered. Any input change therefore reaches the output on the third rising clock edge after it is applied.

Top module: `diag_error_merge`

## Requirements
- R1: While `rst` is high at a rising edge, the card error, the sticky latch and the synchronizers are cleared, and `card_err` reads 0 on the next cycle.
- R2: With `selftest` = 0, no fault line high and the latch clear, `card_err` is 0 whenever all three `err_n` bits are 1.
- R3: With `selftest` = 0, `card_err` is 1 whenever at least one `err_n` bit is 0.
- R4: With `selftest` = 1, the `err_n` lines raise `card_err` only when all three bits are 0. Any pattern with at least one bit at 1 gives 0, unless a fault or the latch holds the error.
- R5: A 1 on either `drv_fault` bit raises `card_err` and sets the sticky latch, in either mode. After the fault line returns to 0, `card_err` stays 1.
- R6: A `clr_pulse` = 1 seen while both `drv_fault` bits are 0 clears the latch. `card_err` then falls to 0 if the decoded error lines show no error.
- R7: A `clr_pulse` = 1 seen while a `drv_fault` bit is 1 leaves the latch set. The fault wins over the clear in that cycle, and the error is still held after both inputs drop.
- R8: An input change applied before rising edge k is visible on `card_err` after edge k+2, and not before. That is two synchronizer stages plus the output register.
- R9: A clear pulse does not mask an error present on the `err_n` lines. `card_err` stays 1 while a line in normal mode is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| err_n | input | 3 | Active-low error lines (NUM_ERR) |
| drv_fault | input | 2 | Active-high driver-fault lines (NUM_FLT) |
| selftest | input | 1 | 1 selects self-test decoding, 0 normal decoding |
| clr_pulse | input | 1 | Operator clear of the sticky latch |
| card_err | output | 1 | Registered card error flag |

## Verification
On every cycle, the assertions check that the latch behaves correctly after synchronization. A fault sets it, it holds without a clear, and a clear with no fault empties it. They also check that a low line in normal mode, or a partial pattern in self-test with nothing latched, drives the next output value. The ordering stories can only be shown by the bench's scenarios. These include an error that persists after its fault is gone, a clear that loses to a fault and must be repeated, leaving self-test followed by a clear, reset in the middle of a latched error, and the exact three-edge latency.

// File: rtl/dem_pkg.sv
package dem_pkg;
  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_SELFTEST = 1'b1
  } dem_mode_e;
endpackage

// File: rtl/dem_sync.sv
module dem_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else if (g == 0) pipe[g] <= d;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dem_decode.sv
module dem_decode
  import dem_pkg::*;
#(
  parameter int NUM_ERR = 3
) (
  input  dem_mode_e            mode,
  input  logic [NUM_ERR-1:0]   err_n_s,
  output logic                 line_err
);
  always_comb begin
    case (mode)
      MODE_SELFTEST: line_err = ~(|err_n_s);
      default:       line_err = ~(&err_n_s);
    endcase
  end
endmodule

// File: rtl/dem_sticky.sv
module dem_sticky #(
  parameter int NUM_FLT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FLT-1:0] fault_s,
  input  logic               clr_s,
  output logic               latch_q,
  output logic               latch_nx
);
  logic fault_any;

  assign fault_any = |fault_s;
  assign latch_nx  = fault_any | (latch_q & ~clr_s);

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_nx;
  end

  // R5
  fault_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|fault_s) |=> latch_q);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !clr_s) |=> latch_q);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_s && !(|fault_s)) |=> !latch_q);
endmodule

// File: rtl/diag_error_merge.sv
module diag_error_merge
  import dem_pkg::*;
#(
  parameter int NUM_ERR     = 3,
  parameter int NUM_FLT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_n,
  input  logic [NUM_FLT-1:0] drv_fault,
  input  logic               selftest,
  input  logic               clr_pulse,
  output logic               card_err
);
  localparam int              BUS_W    = NUM_ERR + NUM_FLT + 2;
  localparam logic [BUS_W-1:0] BUS_IDLE = {2'b00, {NUM_FLT{1'b0}}, {NUM_ERR{1'b1}}};

  logic [BUS_W-1:0]   bus_raw, bus_s;
  logic [NUM_ERR-1:0] err_n_s;
  logic [NUM_FLT-1:0] flt_s;
  logic               mode_s, clr_s;
  logic               line_err, latch_q, latch_nx;

  assign bus_raw = {selftest, clr_pulse, drv_fault, err_n};

  dem_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_raw),
    .q   (bus_s)
  );

  assign err_n_s = bus_s[NUM_ERR-1:0];
  assign flt_s   = bus_s[NUM_ERR +: NUM_FLT];
  assign clr_s   = bus_s[BUS_W-2];
  assign mode_s  = bus_s[BUS_W-1];

  dem_decode #(.NUM_ERR(NUM_ERR)) u_decode (
    .mode     (dem_mode_e'(mode_s)),
    .err_n_s  (err_n_s),
    .line_err (line_err)
  );

  dem_sticky #(.NUM_FLT(NUM_FLT)) u_sticky (
    .clk      (clk),
    .rst      (rst),
    .fault_s  (flt_s),
    .clr_s    (clr_s),
    .latch_q  (latch_q),
    .latch_nx (latch_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) card_err <= 1'b0;
    else     card_err <= line_err | latch_nx;
  end

  // R3
  normal_low_line_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && !(&err_n_s)) |=> card_err);

  // R4
  selftest_partial_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_s && (|err_n_s) && !(|flt_s) && !latch_q) |=> !card_err);

  // R5
  fault_raises_chk: assert property (@(posedge clk) disable iff (rst)
    (|flt_s) |=> card_err);
endmodule

// File: tb/sim_diag_error_merge.sv
`timescale 1ns/1ps
module sim_diag_error_merge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] err_n = 3'b111;
  logic [1:0] drv_fault = 2'b00;
  logic       selftest = 1'b0;
  logic       clr_pulse = 1'b0;
  logic       card_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  diag_error_merge u0 (
    .clk       (clk),
    .rst       (rst),
    .err_n     (err_n),
    .drv_fault (drv_fault),
    .selftest  (selftest),
    .clr_pulse (clr_pulse),
    .card_err  (card_err)
  );

  // {req[3:0], selftest, err_n[2:0], drv_fault[1:0], clr, expected}
  localparam int NV = 23;
  localparam logic [11:0] VEC [NV] = '{
    {4'd2, 1'b0, 3'b111, 2'b00, 1'b0, 1'b0}, // R2 idle
    {4'd3, 1'b0, 3'b110, 2'b00, 1'b0, 1'b1}, // R3 bit0 low
    {4'd3, 1'b0, 3'b101, 2'b00, 1'b0, 1'b1}, // R3 bit1 low
    {4'd3, 1'b0, 3'b011, 2'b00, 1'b0, 1'b1}, // R3 bit2 low
    {4'd3, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1}, // R3 all low
    {4'd4, 1'b1, 3'b000, 2'b00, 1'b0, 1'b1}, // R4 all low in self-test
    {4'd4, 1'b1, 3'b001, 2'b00, 1'b0, 1'b0}, // R4 partial
    {4'd4, 1'b1, 3'b110, 2'b00, 1'b0, 1'b0}, // R4 partial
    {4'd4, 1'b1, 3'b111, 2'b00, 1'b0, 1'b0}, // R4 none low
    {4'd2, 1'b0, 3'b111, 2'b00, 1'b0, 1'b0}, // R2 back to normal
    {4'd5, 1'b0, 3'b111, 2'b01, 1'b0, 1'b1}, // R5 fault 0
    {4'd5, 1'b0, 3'b111, 2'b00, 1'b0, 1'b1}, // R5 sticky
    {4'd6, 1'b0, 3'b111, 2'b00, 1'b1, 1'b0}, // R6 clear
    {4'd6, 1'b0, 3'b111, 2'b00, 1'b0, 1'b0}, // R6 stays clear
    {4'd5, 1'b0, 3'b111, 2'b10, 1'b0, 1'b1}, // R5 fault 1
    {4'd7, 1'b0, 3'b111, 2'b10, 1'b1, 1'b1}, // R7 clear loses to fault
    {4'd7, 1'b0, 3'b111, 2'b00, 1'b0, 1'b1}, // R7 still latched
    {4'd6, 1'b0, 3'b111, 2'b00, 1'b1, 1'b0}, // R6 second clear works
    {4'd9, 1'b0, 3'b110, 2'b00, 1'b1, 1'b1}, // R9 clear cannot mask line
    {4'd5, 1'b1, 3'b111, 2'b01, 1'b0, 1'b1}, // R5 fault in self-test
    {4'd5, 1'b1, 3'b111, 2'b00, 1'b0, 1'b1}, // R5 held in self-test
    {4'd6, 1'b0, 3'b111, 2'b00, 1'b1, 1'b0}, // R6 exit self-test and clear
    {4'd2, 1'b0, 3'b111, 2'b00, 1'b0, 1'b0}  // R2 quiet
  };

  task automatic check(input logic exp, input string tag);
    total++;
    if (card_err !== exp) begin
      bad++;
      $display("FAIL %s: card_err=%b expected=%b at %0t", tag, card_err, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1'b0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      selftest  = VEC[i][7];
      err_n     = VEC[i][6:4];
      drv_fault = VEC[i][3:2];
      clr_pulse = VEC[i][1];
      settle();
      check(VEC[i][0], $sformatf("R%0d vector %0d", VEC[i][11:8], i));
    end

    // R8: exact latency from a quiet state
    selftest = 1'b0; drv_fault = 2'b00; clr_pulse = 1'b0; err_n = 3'b111;
    settle();
    err_n = 3'b101;
    @(posedge clk); @(negedge clk);
    check(1'b0, "R8 edge 1");
    @(posedge clk); @(negedge clk);
    check(1'b0, "R8 edge 2");
    @(posedge clk); @(negedge clk);
    check(1'b1, "R8 edge 3");
    err_n = 3'b111;
    settle();
    check(1'b0, "R8 line released");

    // R1: reset in the middle of a latched error
    drv_fault = 2'b01;
    settle();
    drv_fault = 2'b00;
    settle();
    check(1'b1, "R5 latched before reset");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1'b0, "R1 reset clears output");
    rst = 1'b0;
    settle();
    check(1'b0, "R1 latch cleared by reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule